// File: doc/BRIEF.md
# Single-to-Double Floating-Point Widener

This unit turns a 32-bit IEEE-754 single-precision word into the equal 64-bit double-precision value. It sits after a single-precision floating-point load, where the loaded word has to be stored as a double in a floating-point register. One result is produced per clock, with one cycle of latency. Each input word comes with a valid strobe, and each result leaves with one.

The single word is split MSB-first: the sign in bit 31, an 8-bit exponent in bits 30:23, and a 23-bit fraction in bits 22:0. The double has its sign in bit 63, an 11-bit exponent in bits 62:52, and a 52-bit fraction in bits 51:0. Normal operands need no adder for the exponent. The new exponent is formed by copying the top exponent bit, inserting three inverted copies of it, and keeping the low seven bits. Zero, infinity and NaN use the same layout with the three inserted bits left uninverted. Denormal singles are turned into normal doubles in a single step: a leading-zero count drives a shift. Rounding and exception flags are not part of this unit.

Top module: `s2d_widen`

## Requirements
- R1: For an input exponent from 1 to 254, the output sign equals the input sign, the output exponent (bits 62:52) equals the input exponent plus 896, and output bits 51:0 are the input fraction followed by 29 zero bits (for example 0x42013333 gives 0x4040266660000000).
- R2: An input with exponent 0 and fraction 0 gives a double zero with the same sign: 0x0000000000000000 or 0x8000000000000000.
- R3: An input with exponent 255 gives output exponent 0x7FF, the input sign, and output bits 51:0 equal to the input fraction followed by 29 zeros, so the quiet bit (fraction MSB) and any signalling payload are kept.
- R4: An input with exponent 0 and a nonzero fraction whose highest set bit is at position p (0..22) gives output exponent 874 + p, the input sign, and output bits 51:0 equal to the fraction bits below position p, left-aligned, with zeros after them.
- R5: out_vld is high in the cycle after a rising edge at which in_vld was high and rst was low, and low in the cycle after a rising edge at which in_vld was low.
- R6: When in_vld is low at a rising edge, out_word keeps its previous value, whatever in_word holds.
- R7: A rising edge with rst high sets out_word to zero and out_vld low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | in_word holds a word to convert |
| in_word | input | 32 | Single-precision operand |
| out_vld | output | 1 | out_word holds a fresh result |
| out_word | output | 64 | Double-precision result |

## Verification
Faults in this unit show up as wrong output bits one cycle after the input edge. No state lingers beyond the single output register. A miscounted leading-zero position gives an exponent off by the miscount and a fraction shifted by the same amount, so a test of every denormal bit position catches the error at its first occurrence. If the inverted and uninverted insert bits are swapped, normals get an exponent wrong by a multiple of 128 and infinities lose their all-ones exponent. A register that loads when it should hold shows up in the first idle cycle after a change on in_word.

// File: rtl/s2d_pkg.sv
package s2d_pkg;

    localparam int SP_W       = 32;
    localparam int SP_EXP_W   = 8;
    localparam int SP_FRAC_W  = 23;
    localparam int DP_W       = 64;
    localparam int DP_EXP_W   = 11;
    localparam int DP_FRAC_W  = 52;
    localparam int SP_BIAS    = (1 << (SP_EXP_W - 1)) - 1;
    localparam int DP_BIAS    = (1 << (DP_EXP_W - 1)) - 1;
    localparam int REBIAS     = DP_BIAS - SP_BIAS;
    localparam int PAD_W      = DP_FRAC_W - SP_FRAC_W;
    localparam int INSERT_W   = DP_EXP_W - SP_EXP_W;
    localparam int LZ_W       = $clog2(SP_FRAC_W);

    typedef struct packed {
        logic                  sign;
        logic [SP_EXP_W-1:0]   exp;
        logic [SP_FRAC_W-1:0]  frac;
    } sp_t;

    typedef struct packed {
        logic                  sign;
        logic [DP_EXP_W-1:0]   exp;
        logic [DP_FRAC_W-1:0]  frac;
    } dp_t;

    typedef enum logic [1:0] {
        CLS_NORMAL  = 2'd0,
        CLS_DENORM  = 2'd1,
        CLS_SPECIAL = 2'd2
    } opclass_e;

    function automatic logic [DP_FRAC_W-1:0] pad_frac(input logic [SP_FRAC_W-1:0] f);
        return {f, {PAD_W{1'b0}}};
    endfunction

    function automatic logic [DP_EXP_W-1:0] widen_exp(input logic [SP_EXP_W-1:0] e,
                                                      input logic invert);
        return {e[SP_EXP_W-1], {INSERT_W{e[SP_EXP_W-1] ^ invert}}, e[SP_EXP_W-2:0]};
    endfunction

endpackage

// File: rtl/s2d_classify.sv
module s2d_classify
    import s2d_pkg::*;
(
    input  sp_t      op,
    output opclass_e cls
);
    logic exp_zero;
    logic exp_ones;
    logic frac_zero;

    always_comb begin
        exp_zero  = (op.exp == '0);
        exp_ones  = (op.exp == '1);
        frac_zero = (op.frac == '0);
        if (exp_ones || (exp_zero && frac_zero))
            cls = CLS_SPECIAL;
        else if (exp_zero)
            cls = CLS_DENORM;
        else
            cls = CLS_NORMAL;
    end
endmodule

// File: rtl/s2d_lzc.sv
module s2d_lzc #(
    parameter int W   = 23,
    parameter int CNT_W = $clog2(W)
) (
    input  logic [W-1:0]     vec,
    output logic [CNT_W-1:0] cnt,
    output logic             none
);
    always_comb begin
        cnt  = '0;
        none = 1'b1;
        for (int i = 0; i < W; i++) begin
            if (none && vec[W-1-i]) begin
                cnt  = CNT_W'(i);
                none = 1'b0;
            end
        end
    end
endmodule

// File: rtl/s2d_denorm.sv
module s2d_denorm
    import s2d_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [SP_FRAC_W-1:0]  frac,
    output logic [DP_EXP_W-1:0]   exp_out,
    output logic [SP_FRAC_W-1:0]  frac_out
);
    logic [LZ_W-1:0]      lz;
    logic                 none;
    logic [SP_FRAC_W-1:0] aligned;

    s2d_lzc #(.W(SP_FRAC_W), .CNT_W(LZ_W)) u_lzc (
        .vec  (frac),
        .cnt  (lz),
        .none (none)
    );

    always_comb begin
        aligned  = frac << lz;
        frac_out = aligned << 1;
        exp_out  = DP_EXP_W'(REBIAS) - DP_EXP_W'(lz);
    end

    // The shift chosen by the counter must bring a one to the top.
    AST_LEAD_ONE: assert property (@(posedge clk) disable iff (rst)
        (!none) |-> aligned[SP_FRAC_W-1]) else $error("lead one"); // R4

    AST_DEN_EXP_RANGE: assert property (@(posedge clk) disable iff (rst)
        (!none) |-> (exp_out >= DP_EXP_W'(REBIAS - SP_FRAC_W + 1) &&
                     exp_out <= DP_EXP_W'(REBIAS))) else $error("den exp"); // R4
endmodule

// File: rtl/s2d_assemble.sv
module s2d_assemble
    import s2d_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  sp_t                   op,
    input  opclass_e              cls,
    input  logic [DP_EXP_W-1:0]   den_exp,
    input  logic [SP_FRAC_W-1:0]  den_frac,
    output dp_t                   res
);
    always_comb begin
        res.sign = op.sign;
        unique case (cls)
            CLS_NORMAL: begin
                res.exp  = widen_exp(op.exp, 1'b1);
                res.frac = pad_frac(op.frac);
            end
            CLS_DENORM: begin
                res.exp  = den_exp;
                res.frac = pad_frac(den_frac);
            end
            default: begin
                res.exp  = widen_exp(op.exp, 1'b0);
                res.frac = pad_frac(op.frac);
            end
        endcase
    end

    // Bit replication must match an arithmetic rebias for every normal.
    AST_NORM_REBIAS: assert property (@(posedge clk) disable iff (rst)
        (cls == CLS_NORMAL) |->
            (res.exp == DP_EXP_W'(op.exp) + DP_EXP_W'(REBIAS))) else $error("rebias"); // R1

    AST_SPECIAL_TOP: assert property (@(posedge clk) disable iff (rst)
        (op.exp == '1) |-> (res.exp == '1)) else $error("special exp"); // R3

    AST_ZERO_OUT: assert property (@(posedge clk) disable iff (rst)
        (op.exp == '0 && op.frac == '0) |->
            (res.exp == '0 && res.frac == '0)) else $error("zero"); // R2
endmodule

// File: rtl/s2d_widen.sv
module s2d_widen
    import s2d_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_vld,
    input  logic [31:0]   in_word,
    output logic          out_vld,
    output logic [63:0]   out_word
);
    sp_t                   op;
    opclass_e              cls;
    logic [DP_EXP_W-1:0]   den_exp;
    logic [SP_FRAC_W-1:0]  den_frac;
    dp_t                   res;
    dp_t                   res_q;
    logic                  vld_q;

    assign op = sp_t'(in_word);

    s2d_classify u_cls (
        .op  (op),
        .cls (cls)
    );

    s2d_denorm u_den (
        .clk      (clk),
        .rst      (rst),
        .frac     (op.frac),
        .exp_out  (den_exp),
        .frac_out (den_frac)
    );

    s2d_assemble u_asm (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .cls      (cls),
        .den_exp  (den_exp),
        .den_frac (den_frac),
        .res      (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= in_vld;
            if (in_vld)
                res_q <= res;
        end
    end

    assign out_vld  = vld_q;
    assign out_word = res_q;

    AST_VLD_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld) else $error("vld follow"); // R5

    AST_VLD_DROP: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld) else $error("vld drop"); // R5

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> $stable(out_word)) else $error("hold"); // R6
endmodule

// File: tb/sim_s2d_widen.sv
module sim_s2d_widen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [31:0] in_word = '0;
    logic        out_vld;
    logic [63:0] out_word;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    s2d_widen u0 (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (in_vld),
        .in_word  (in_word),
        .out_vld  (out_vld),
        .out_word (out_word)
    );

    // {input word, expected double}
    localparam logic [95:0] VEC [12] = '{
        {32'h42013333, 64'h4040266660000000},
        {32'h3F800000, 64'h3FF0000000000000},
        {32'h00800000, 64'h3810000000000000},
        {32'h7F7FFFFF, 64'h47EFFFFFE0000000},
        {32'h00000000, 64'h0000000000000000},
        {32'h80000000, 64'h8000000000000000},
        {32'h7F800000, 64'h7FF0000000000000},
        {32'hFF800000, 64'hFFF0000000000000},
        {32'h7FC00000, 64'h7FF8000000000000},
        {32'h7F800001, 64'h7FF0000020000000},
        {32'h00000001, 64'h36A0000000000000},
        {32'h007FFFFF, 64'h380FFFFFC0000000}
    };

    function automatic string tag_of(input logic [31:0] w);
        if (w[30:23] == 8'hFF) return "R3";
        if (w[30:23] == 8'h00 && w[22:0] == '0) return "R2";
        if (w[30:23] == 8'h00) return "R4";
        return "R1";
    endfunction

    // Arithmetic model: rebias by adding, renormalise by searching.
    function automatic logic [63:0] model(input logic [31:0] w);
        logic [10:0] e;
        logic [22:0] f;
        int p;
        f = w[22:0];
        if (w[30:23] == 8'hFF) return {w[31], 11'h7FF, f, 29'b0};
        if (w[30:23] == 8'h00 && f == '0) return {w[31], 63'b0};
        if (w[30:23] == 8'h00) begin
            p = 0;
            for (int i = 0; i < 23; i++) if (f[i]) p = i;
            e = 11'(874 + p);
            f = 23'(f << (23 - p));
            return {w[31], e, f, 29'b0};
        end
        e = 11'(w[30:23]) + 11'd896;
        return {w[31], e, f, 29'b0};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic convert(input logic [31:0] w, input logic [63:0] exp, input string req);
        @(negedge clk);
        in_word = w;
        in_vld  = 1'b1;
        @(negedge clk);
        in_vld  = 1'b0;
        check(req, $sformatf("word %h", w), out_word, exp);
        check("R5", "valid after one cycle", {63'b0, out_vld}, 64'd1);
    endtask

    initial begin
        logic [31:0] w;
        logic [63:0] held;
        repeat (3) @(negedge clk);
        check("R7", "reset data", out_word, 64'd0);
        check("R7", "reset valid", {63'b0, out_vld}, 64'd0);
        rst = 1'b0;

        foreach (VEC[i])
            convert(VEC[i][95:64], VEC[i][63:0], tag_of(VEC[i][95:64]));

        // every denormal leading-one position, both signs
        for (int p = 0; p < 23; p++) begin
            w = {1'b0, 8'h00, 23'(1 << p) | 23'($urandom & ((1 << p) - 1))};
            if (p % 2 == 1) w[31] = 1'b1;
            convert(w, model(w), "R4");
        end

        // random normals
        for (int k = 0; k < 200; k++) begin
            w = $urandom;
            if (w[30:23] == 8'h00 || w[30:23] == 8'hFF) w[30:23] = 8'h7E;
            convert(w, model(w), "R1");
        end

        // signalling NaN with payload, negative quiet NaN
        convert(32'h7FA00005, model(32'h7FA00005), "R3");
        convert(32'hFFC12345, model(32'hFFC12345), "R3");

        // idle cycles: data holds, valid low
        held = out_word;
        @(negedge clk);
        in_word = 32'h3F800000;
        in_vld  = 1'b0;
        @(negedge clk);
        check("R6", "hold while idle", out_word, held);
        check("R5", "valid low when idle", {63'b0, out_vld}, 64'd0);
        in_word = 32'h00000001;
        @(negedge clk);
        check("R6", "hold second idle", out_word, held);

        // back-to-back stream
        @(negedge clk);
        in_vld = 1'b1;
        in_word = 32'h40490FDB;
        @(negedge clk);
        check("R1", "stream 1", out_word, model(32'h40490FDB));
        in_word = 32'h00012345;
        @(negedge clk);
        check("R4", "stream 2", out_word, model(32'h00012345));
        check("R5", "stream valid", {63'b0, out_vld}, 64'd1);

        // reset in mid-stream
        rst = 1'b1;
        @(negedge clk);
        check("R7", "mid reset data", out_word, 64'd0);
        check("R7", "mid reset valid", {63'b0, out_vld}, 64'd0);
        in_vld = 1'b0;
        rst = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule